// File: doc/BRIEF.md
# Banked Memory Address Sequencer

This block sits between a simple request port and a banked memory device whose row and column addresses share one set of pins. A requester presents a flat word address with a read or write flag. The sequencer cuts the address into a bank number, a row number and a column number. It then drives the row on the shared bus with the row strobe, and after that the column with the column strobe. When the access is finished, it pulses an acknowledge for one cycle.

Stored charge in the device leaks away, so the sequencer also owns refresh. A programmable interval counter raises a refresh request. Between accesses, that request runs a refresh cycle, which strobes the next row from an internal row counter. The counter steps through every row and wraps. A refresh never breaks into an access that has already started. When a refresh and a new request are both waiting in idle, the refresh goes first.

The word configuration is a parameter. With `WIDE_WORD = 1` (the default, 16-bit words) the column field is 10 bits. With `WIDE_WORD = 0` (4-bit words) it is 12 bits. The row field is 13 bits and the bank field is 2 bits in both configurations. The length of each strobe phase is the parameter `STROBE_CYC` (at least 1). The shared address bus is 13 bits wide, and the column is zero-extended onto it.

Top module: `bank_seq_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, both strobes, the write flag, the acknowledge and the refresh indicator are all low.
- R2: The flat address is split with the bank in the two top bits, the row in the next 13 bits and the column in the low bits (10 bits by default). For example, address bits [24:23] form the bank, [22:10] the row and [9:0] the column.
- R3: After a request is accepted, `mem_row_stb` is high for exactly `STROBE_CYC` cycles. During those cycles the bus carries the row and `mem_bank` carries the bank.
- R4: The cycle after the row phase ends, `mem_col_stb` is high for exactly `STROBE_CYC` cycles, with the zero-extended column on the bus. `mem_we` equals the request's write flag during this phase and is low at every other time. The two strobes are never high together.
- R5: `req_ack` is high for exactly one cycle, the cycle right after the column phase, once per accepted request.
- R6: A request is accepted only in idle. Changes to the address or the write flag after acceptance have no effect on the access in progress.
- R7: With a non-zero `ref_period` P, the refresh requests are P cycles apart, so refresh cycles start P cycles apart when the sequencer is otherwise idle. With P = 0, no refresh happens.
- R8: During a refresh cycle, `ref_active` and `mem_row_stb` are high for `STROBE_CYC` cycles, with bank 0 and the column strobe low. The bus carries a row counter that starts at 0 after reset, steps by one per refresh, and wraps from 8191 to 0.
- R9: When a refresh is pending in idle and a request is also waiting, the refresh runs first and the request follows it.
- R10: A refresh that becomes pending during an access waits until that access has acknowledged, then runs before any further access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Access request, held until seen |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_addr | input | ADDR_W (25) | Flat word address |
| ref_period | input | PER_W (16) | Refresh interval in cycles, 0 disables refresh |
| req_ack | output | 1 | One-cycle completion pulse |
| mem_bank | output | 2 | Bank select to the device |
| mem_addr | output | 13 | Shared row/column address bus |
| mem_row_stb | output | 1 | Row strobe (active high) |
| mem_col_stb | output | 1 | Column strobe (active high) |
| mem_we | output | 1 | Write flag, valid in the column phase |
| ref_active | output | 1 | High during a refresh cycle |

## Verification
The hardest situations to reach from the ports are the two races between refresh and an access. In one, the refresh becomes pending in the very cycle that idle would otherwise accept a waiting request. In the other, the refresh becomes pending in the middle of an access. The bench reaches both by timing. It starts the interval counter from zero at a known edge with a small period. For the first race, it raises the request only in the cycle after the counter has expired. For the second, it raises the request together with the counter start, so the expiry falls inside the row or column phase. Row counter wrap-around is reached by running more than 8192 refresh cycles back to back with a short period.

// File: rtl/bseq_pkg.sv
// Package: shared constants, the state type and the field-width helper
// for the banked memory address sequencer.
// Assumes: the bank and row field widths are fixed for the device family;
// only the column width depends on the word configuration.
package bseq_pkg;

    localparam int BANK_W = 2;
    localparam int ROW_W  = 13;

    // Column width for the selected word configuration.
    function automatic int col_w(input bit wide_word);
        return wide_word ? 10 : 12;
    endfunction

    // Width of the shared address bus: the wider of row and column.
    function automatic int mux_w(input bit wide_word);
        return (col_w(wide_word) > ROW_W) ? col_w(wide_word) : ROW_W;
    endfunction

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ROW  = 3'd1,
        ST_COL  = 3'd2,
        ST_DONE = 3'd3,
        ST_REFR = 3'd4
    } seq_state_t;

endpackage

// File: rtl/bseq_addr_latch.sv
// Module: captures one request when the sequencer accepts it and splits
// the flat address into bank, row and column (column zero-extended to
// the shared bus width).
// Assumes: load is asserted for one cycle, only in idle; the fields are
// held stable until the next load.
module bseq_addr_latch #(
    parameter bit WIDE_WORD = 1'b1,
    localparam int COL_W  = bseq_pkg::col_w(WIDE_WORD),
    localparam int MUX_W  = bseq_pkg::mux_w(WIDE_WORD),
    localparam int ADDR_W = bseq_pkg::BANK_W + bseq_pkg::ROW_W + COL_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [ADDR_W-1:0]           addr_in,
    input  logic                        write_in,
    output logic [bseq_pkg::BANK_W-1:0] bank_q,
    output logic [MUX_W-1:0]            row_q,
    output logic [MUX_W-1:0]            col_q,
    output logic                        write_q
);
    localparam int ROW_LSB  = COL_W;
    localparam int BANK_LSB = COL_W + bseq_pkg::ROW_W;

    logic [bseq_pkg::ROW_W-1:0] row_f;
    logic [COL_W-1:0]           col_f;
    logic [MUX_W-1:0]           row_ext;
    logic [MUX_W-1:0]           col_ext;

    assign row_f = addr_in[BANK_LSB-1:ROW_LSB];
    assign col_f = addr_in[COL_W-1:0];

    // Widen the narrower field onto the shared bus width.
    generate
        if (COL_W < MUX_W) begin : g_pad_col
            assign col_ext = {{(MUX_W-COL_W){1'b0}}, col_f};
        end else begin : g_full_col
            assign col_ext = col_f;
        end
        if (bseq_pkg::ROW_W < MUX_W) begin : g_pad_row
            assign row_ext = {{(MUX_W-bseq_pkg::ROW_W){1'b0}}, row_f};
        end else begin : g_full_row
            assign row_ext = row_f;
        end
    endgenerate

    // Hold the fields of the accepted request for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q  <= '0;
            row_q   <= '0;
            col_q   <= '0;
            write_q <= 1'b0;
        end else if (load) begin
            bank_q  <= addr_in[ADDR_W-1:BANK_LSB];
            row_q   <= row_ext;
            col_q   <= col_ext;
            write_q <= write_in;
        end
    end

endmodule

// File: rtl/bseq_refresh_timer.sv
// Module: interval counter that raises a refresh-pending flag every
// ref_period cycles (0 = off), plus the row counter that refresh walks.
// Assumes: grant pulses for one cycle when a refresh starts, done pulses
// in the last cycle of that refresh; the row counter wraps naturally.
module bseq_refresh_timer #(
    parameter int PER_W = 16,
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] ref_period,
    input  logic             grant,
    input  logic             done,
    output logic             pend,
    output logic [ROW_W-1:0] ref_row
);
    logic [PER_W-1:0] tick_cnt;
    logic             tick;

    assign tick = (ref_period != '0) && (tick_cnt >= ref_period - PER_W'(1));

    // Count cycles toward the next refresh request; held at 0 when off.
    always_ff @(posedge clk) begin
        if (!rst_n || ref_period == '0 || tick) begin
            tick_cnt <= '0;
        end else begin
            tick_cnt <= tick_cnt + PER_W'(1);
        end
    end

    // Pending flag: a new tick wins over a same-cycle grant so none is lost.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (tick) begin
            pend <= 1'b1;
        end else if (grant) begin
            pend <= 1'b0;
        end
    end

    // Advance to the next row after each completed refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_row <= '0;
        end else if (done) begin
            ref_row <= ref_row + ROW_W'(1);
        end
    end

    p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !tick) |=> !pend);
    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_period == '0 && !pend) |=> !pend);
    p_row_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ref_row == $past(ref_row) + ROW_W'(1)));

endmodule

// File: rtl/bseq_fsm.sv
// Module: phase sequencer. Walks IDLE -> ROW -> COL -> DONE for an access
// and IDLE -> REFR -> IDLE for a refresh, each strobe phase lasting
// STROBE_CYC cycles. Refresh wins in idle; nothing preempts a phase.
// Assumes: STROBE_CYC >= 1; req_valid is a level held by the requester.
module bseq_fsm #(
    parameter int STROBE_CYC = 2,
    localparam int CNT_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 ref_pend,
    output bseq_pkg::seq_state_t state,
    output logic                 accept,
    output logic                 ref_grant,
    output logic                 ref_done
);
    import bseq_pkg::*;

    seq_state_t       nxt;
    logic [CNT_W-1:0] cnt;
    logic             last;

    assign last = (cnt == CNT_W'(STROBE_CYC - 1));

    // Next-state choice and the one-cycle event flags.
    always_comb begin
        nxt       = state;
        accept    = 1'b0;
        ref_grant = 1'b0;
        ref_done  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (ref_pend) begin
                    nxt       = ST_REFR;
                    ref_grant = 1'b1;
                end else if (req_valid) begin
                    nxt    = ST_ROW;
                    accept = 1'b1;
                end
            end
            ST_ROW:  if (last) nxt = ST_COL;
            ST_COL:  if (last) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            ST_REFR: begin
                if (last) begin
                    nxt      = ST_IDLE;
                    ref_done = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Phase length counter, restarted on every state change.
    always_ff @(posedge clk) begin
        if (!rst_n || nxt != state) cnt <= '0;
        else                        cnt <= cnt + CNT_W'(1);
    end

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_DONE) |-> (int'(cnt) < STROBE_CYC));
    p_ref_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ref_pend) |=> (state == ST_REFR));
    p_no_preempt_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ROW || state == ST_COL) |=> (state != ST_REFR));
    p_ref_from_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_REFR) |-> ($past(state) == ST_IDLE));

endmodule

// File: rtl/bank_seq_ctrl.sv
// Module: top of the banked memory address sequencer. Latches a request,
// sequences row then column strobes on the shared bus, acknowledges, and
// interleaves refresh cycles between accesses.
// Assumes: synchronous active-low reset; outputs decode from registered
// state and latched fields, so they change only after a clock edge.
module bank_seq_ctrl #(
    parameter bit WIDE_WORD  = 1'b1,
    parameter int STROBE_CYC = 2,
    parameter int PER_W      = 16,
    localparam int COL_W  = bseq_pkg::col_w(WIDE_WORD),
    localparam int MUX_W  = bseq_pkg::mux_w(WIDE_WORD),
    localparam int ADDR_W = bseq_pkg::BANK_W + bseq_pkg::ROW_W + COL_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [PER_W-1:0]            ref_period,
    output logic                        req_ack,
    output logic [bseq_pkg::BANK_W-1:0] mem_bank,
    output logic [MUX_W-1:0]            mem_addr,
    output logic                        mem_row_stb,
    output logic                        mem_col_stb,
    output logic                        mem_we,
    output logic                        ref_active
);
    import bseq_pkg::*;

    seq_state_t                 state;
    logic                       accept;
    logic                       ref_grant;
    logic                       ref_done;
    logic                       ref_pend;
    logic [ROW_W-1:0]           ref_row;
    logic [BANK_W-1:0]          bank_q;
    logic [MUX_W-1:0]           row_q;
    logic [MUX_W-1:0]           col_q;
    logic                       write_q;
    logic [MUX_W-1:0]           ref_row_ext;

    bseq_fsm #(.STROBE_CYC(STROBE_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ref_pend  (ref_pend),
        .state     (state),
        .accept    (accept),
        .ref_grant (ref_grant),
        .ref_done  (ref_done)
    );

    bseq_addr_latch #(.WIDE_WORD(WIDE_WORD)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .addr_in  (req_addr),
        .write_in (req_write),
        .bank_q   (bank_q),
        .row_q    (row_q),
        .col_q    (col_q),
        .write_q  (write_q)
    );

    bseq_refresh_timer #(.PER_W(PER_W), .ROW_W(ROW_W)) u_refresh (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_period (ref_period),
        .grant      (ref_grant),
        .done       (ref_done),
        .pend       (ref_pend),
        .ref_row    (ref_row)
    );

    generate
        if (ROW_W < MUX_W) begin : g_pad_ref
            assign ref_row_ext = {{(MUX_W-ROW_W){1'b0}}, ref_row};
        end else begin : g_full_ref
            assign ref_row_ext = ref_row;
        end
    endgenerate

    // Drive the device pins from the current phase.
    always_comb begin
        mem_bank    = '0;
        mem_addr    = '0;
        mem_row_stb = 1'b0;
        mem_col_stb = 1'b0;
        mem_we      = 1'b0;
        ref_active  = 1'b0;
        req_ack     = 1'b0;
        unique case (state)
            ST_ROW: begin
                mem_bank    = bank_q;
                mem_addr    = row_q;
                mem_row_stb = 1'b1;
            end
            ST_COL: begin
                mem_bank    = bank_q;
                mem_addr    = col_q;
                mem_col_stb = 1'b1;
                mem_we      = write_q;
            end
            ST_DONE: req_ack = 1'b1;
            ST_REFR: begin
                mem_addr    = ref_row_ext;
                mem_row_stb = 1'b1;
                ref_active  = 1'b1;
            end
            default: ;
        endcase
    end

    p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_row_stb && mem_col_stb));
    p_we_in_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_col_stb);
    p_col_after_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_col_stb) |-> ($past(mem_row_stb) && !$past(ref_active)));
    p_ack_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |=> !req_ack);
    p_ack_after_col_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> $past(mem_col_stb));
    p_latch_only_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_row_stb && !ref_active) |=> $stable(bank_q) && $stable(row_q) && $stable(col_q));

endmodule

// File: tb/sim_bank_seq_ctrl.sv
`timescale 1ns/1ps
module sim_bank_seq_ctrl;
    localparam int S      = 2;
    localparam int ADDR_W = 25;
    localparam int MUX_W  = 13;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [15:0]       ref_period = '0;
    logic              req_ack;
    logic [1:0]        mem_bank;
    logic [MUX_W-1:0]  mem_addr;
    logic              mem_row_stb, mem_col_stb, mem_we, ref_active;

    int total = 0;
    int bad = 0;

    bank_seq_ctrl #(.WIDE_WORD(1'b1), .STROBE_CYC(S), .PER_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .ref_period(ref_period), .req_ack(req_ack),
        .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_row_stb(mem_row_stb),
        .mem_col_stb(mem_col_stb), .mem_we(mem_we), .ref_active(ref_active)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Refresh observer: row sequence, bank, length and spacing (R7, R8).
    logic [12:0] exp_ref_row = '0;
    int  ref_total = 0;
    int  cyc = 0;
    int  last_start = 0;
    int  ref_gap = 0;
    int  ref_len = 0;
    bit  ref_prev = 1'b0;
    bit  saw_wrap = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (ref_active && !ref_prev) begin
                chk(mem_addr == exp_ref_row, "R8 refresh row", mem_addr, exp_ref_row);
                chk(mem_bank == 2'd0 && !mem_col_stb && mem_row_stb, "R8 refresh pins",
                    {mem_bank, mem_col_stb, mem_row_stb}, 4'b0001);
                if (mem_addr == '0 && ref_total > 0) saw_wrap = 1'b1;
                ref_gap    = cyc - last_start;
                last_start = cyc;
                exp_ref_row++;
                ref_total++;
                ref_len = 0;
            end
            if (ref_active) ref_len++;
            if (!ref_active && ref_prev) chk(ref_len == S, "R8 refresh length", ref_len, S);
            ref_prev = ref_active;
        end
    end

    // One access: drive the request, watch the phases, check each one.
    task automatic do_access(input logic [ADDR_W-1:0] a, input logic w,
                             input bit ref_first, input bit ref_after, input string tag);
        int rows = 0, cols = 0, acks = 0;
        bit ref_before = 0, ref_inside = 0, seen = 0;
        req_addr = a; req_write = w; req_valid = 1'b1;
        for (int i = 0; i < 60 && acks == 0; i++) begin
            @(negedge clk);
            if (ref_active) begin
                if (rows == 0) ref_before = 1;
                else ref_inside = 1;
                ref_period = '0;
            end
            if (mem_row_stb && !ref_active) begin
                if (rows == 0) begin
                    req_addr = ~a; req_write = ~w; req_valid = 1'b0;
                end
                rows++;
                chk(mem_addr == a[22:10], {tag, " R3 row addr"}, mem_addr, a[22:10]);
                chk(mem_bank == a[24:23], {tag, " R2 bank"}, mem_bank, a[24:23]);
                chk(!mem_we, {tag, " R4 we outside column"}, mem_we, 0);
            end
            if (mem_col_stb) begin
                cols++;
                chk(rows == S, {tag, " R3 row length"}, rows, S);
                chk(mem_addr == {3'b000, a[9:0]}, {tag, " R2 R6 column addr"}, mem_addr, a[9:0]);
                chk(mem_we == w, {tag, " R4 R6 write flag"}, mem_we, w);
            end
            if (req_ack) begin
                acks++;
                chk(cols == S, {tag, " R4 R5 column length"}, cols, S);
                ref_period = '0;
            end
        end
        chk(acks == 1, {tag, " R5 ack seen"}, acks, 1);
        @(negedge clk);
        chk(!req_ack, {tag, " R5 ack one cycle"}, req_ack, 0);
        chk(!ref_inside, {tag, " R10 no refresh inside access"}, ref_inside, 0);
        chk(ref_before == ref_first, {tag, " R9 refresh order"}, ref_before, ref_first);
        if (ref_after) begin
            for (int i = 0; i < 10; i++) begin
                if (ref_active) seen = 1;
                if (!seen) @(negedge clk);
            end
            chk(seen, {tag, " R10 deferred refresh"}, seen, 1);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk({mem_row_stb, mem_col_stb, mem_we, req_ack, ref_active} == 5'b0, "R1 in reset",
            {mem_row_stb, mem_col_stb, mem_we, req_ack, ref_active}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({mem_row_stb, mem_col_stb, mem_we, req_ack, ref_active} == 5'b0, "R1 after reset",
            {mem_row_stb, mem_col_stb, mem_we, req_ack, ref_active}, 0);
    endtask

    task automatic t_refresh_off();
        int t0 = ref_total;
        ref_period = '0;
        repeat (40) @(negedge clk);
        chk(ref_total == t0, "R7 period zero disables refresh", ref_total - t0, 0);
    endtask

    task automatic t_interval();
        int t0 = ref_total;
        @(negedge clk);
        ref_period = 16'd6;
        for (int i = 0; i < 100 && ref_total < t0 + 3; i++) @(negedge clk);
        chk(ref_total >= t0 + 3, "R7 refreshes occur", ref_total - t0, 3);
        chk(ref_gap == 6, "R7 refresh spacing", ref_gap, 6);
        ref_period = '0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_priority();
        @(negedge clk);
        ref_period = 16'd4;
        repeat (4) @(posedge clk);
        @(negedge clk);
        do_access(25'h0ABCDEF, 1'b1, 1'b1, 1'b0, "priority");
    endtask

    task automatic t_defer();
        @(negedge clk);
        ref_period = 16'd3;
        do_access(25'h1234567, 1'b0, 1'b0, 1'b1, "defer");
        repeat (6) @(negedge clk);
    endtask

    task automatic t_wrap();
        int t0 = ref_total;
        @(negedge clk);
        ref_period = 16'd5;
        for (int i = 0; i < 60000 && ref_total < t0 + 8200; i++) @(negedge clk);
        ref_period = '0;
        repeat (10) @(negedge clk);
        chk(ref_total >= t0 + 8200, "R8 long refresh run", ref_total - t0, 8200);
        chk(saw_wrap, "R8 row counter wraps to 0", saw_wrap, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        do_access(25'h1ABCDEF, 1'b1, 1'b0, 1'b0, "write");
        do_access(25'h0555AAA, 1'b0, 1'b0, 1'b0, "read");
        do_access(25'h0000000, 1'b1, 1'b0, 1'b0, "zero");
        do_access(25'h1FFFFFF, 1'b0, 1'b0, 1'b0, "ones");
        t_refresh_off();
        t_interval();
        t_priority();
        t_defer();
        t_wrap();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #900000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule